// File: doc/BRIEF.md
# Hardware Lock Register Bank

This block holds a bank of one-bit mutual-exclusion locks that several bus masters share through one simple register port. A master claims a lock by reading that lock's word. The read is a test-and-set in one step: it returns the previous state and leaves the lock taken. A read that returns 0 means the reader now owns the lock. A read that returns 1 means another master holds it. The owner gives the lock back by writing zero to the same word. No other software step exists, so the protocol costs one bus read to try a lock and one bus write to free it.

The bus has byte addresses, read and write strobes that last one cycle, and 32-bit write data. Read data is registered and appears in the cycle after the read strobe. The port carries at most one access per cycle, so any arbitration between masters is done upstream and two claims can never happen in the same cycle. The number of locks is fixed when the block is built, at 32, 64, 128 or 256. A read-only status word reports that count as a 4-bit code, so software can find the size of the bank at run time.

Top module: `hwlock_bank`

## Requirements
- R1: A read of byte address 0x000 returns the status word. Bits [31:28] hold code N = log2(LOCK_COUNT) - 4, so 32 locks give 1, 64 give 2, 128 give 3 and 256 give 4. All other bits read 0.
- R2: Lock i is at byte address 0x100 + 4*i, for 0 <= i < LOCK_COUNT. Read data appears on busRdata in the cycle after the cycle in which busRd is high.
- R3: A read of a free lock returns 0x00000000 and leaves that lock taken.
- R4: A read of a taken lock returns 0x00000001 and leaves the lock taken.
- R5: A write of 0x00000000 to a lock word frees that lock. Writing zero to a lock that is already free leaves it free.
- R6: A write of any non-zero value to a lock word leaves the lock unchanged.
- R7: After reset every lock is free and busRdata is 0.
- R8: Some addresses are unmapped: byte addresses 0x004 to 0x0FC, lock indices at or above LOCK_COUNT, and any address with bits [1:0] not equal to 0. Reads of these addresses return 0. Writes to them change no lock.
- R9: Writes to the status word are ignored.
- R10: Back-to-back reads of one free lock return 0 to the first reader and 1 to every later reader.
- R11: If busRd and busWr are high in the same cycle, only the read is performed. The write is ignored.
- R12: In the cycle after a cycle with no read of a mapped word, busRdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address |
| busRd | input | 1 | Read strobe, one cycle |
| busWr | input | 1 | Write strobe, one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |

## Verification
The bench builds the bank with LOCK_COUNT = 64 and ADDR_W = 12. With these values the status code is 2, which is not the reset-like default of 1. The highest lock word (0x1FC) and the first index past the end (0x200) are both inside the address space, so the bench can show both the top-of-range boundary and the rejection of an out-of-range index. The tests also cover misaligned aliases of lock 0, overlapping read and write strobes, and releases of a lock that is already free.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;

  // Strobes from decode to the lock datapath; at most one is high per cycle.
  typedef struct packed {
    logic statusRd;
    logic lockRd;
    logic lockRel;
  } lockCmd_t;

  localparam int unsigned LOCK_BASE_BYTE = 32'h100;
  localparam int unsigned DATA_W         = 32;
  localparam int unsigned CODE_W         = 4;

endpackage

// File: rtl/hwlock_ctrl.sv
module hwlock_ctrl
  import hwlock_pkg::*;
#(
  parameter int LOCK_COUNT = 32,
  parameter int ADDR_W     = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busRd,
  input  logic                          busWr,
  input  logic [DATA_W-1:0]             busWdata,
  output lockCmd_t                      cmd,
  output logic [$clog2(LOCK_COUNT)-1:0] lockIdx
);

  localparam int IDX_W     = $clog2(LOCK_COUNT);
  localparam int WA_W      = ADDR_W - 2;
  localparam int BASE_WORD = LOCK_BASE_BYTE / 4;

  logic [WA_W-1:0] wordAddr;
  logic [WA_W-1:0] relWord;
  logic            aligned;
  logic            hitStatus;
  logic            hitLock;
  logic            wrZero;

  assign wordAddr  = busAddr[ADDR_W-1:2];
  assign aligned   = (busAddr[1:0] == 2'b00);
  assign relWord   = wordAddr - WA_W'(BASE_WORD);
  assign hitStatus = aligned && (wordAddr == '0);
  assign hitLock   = aligned && (wordAddr >= WA_W'(BASE_WORD))
                     && (relWord < WA_W'(LOCK_COUNT));
  assign wrZero    = (busWdata == '0);
  assign lockIdx   = relWord[IDX_W-1:0];

  always_comb begin
    cmd          = '0;
    cmd.statusRd = busRd && hitStatus;
    cmd.lockRd   = busRd && hitLock;
    // a read wins over a write in the same cycle
    cmd.lockRel  = busWr && !busRd && hitLock && wrZero;
  end

  // R11
  rd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busRd |-> !cmd.lockRel);

  // R6
  nonzero_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.lockRel |-> (busWdata == '0));

  // R8
  misaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr[1:0] != 2'b00) |-> !(cmd.lockRd || cmd.lockRel || cmd.statusRd));

endmodule

// File: rtl/hwlock_dp.sv
module hwlock_dp
  import hwlock_pkg::*;
#(
  parameter int LOCK_COUNT = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  lockCmd_t                      cmd,
  input  logic [$clog2(LOCK_COUNT)-1:0] lockIdx,
  output logic [DATA_W-1:0]             busRdata
);

  localparam int              IDX_W  = $clog2(LOCK_COUNT);
  localparam logic [CODE_W-1:0] CODE = CODE_W'(IDX_W - 4);
  localparam logic [DATA_W-1:0] STATUS_WORD = {CODE, {(DATA_W-CODE_W){1'b0}}};

  logic [LOCK_COUNT-1:0] lockState;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lockState <= '0;
      busRdata  <= '0;
    end else begin
      busRdata <= '0;
      if (cmd.statusRd) busRdata <= STATUS_WORD;
      if (cmd.lockRd) begin
        busRdata           <= {{(DATA_W-1){1'b0}}, lockState[lockIdx]};
        lockState[lockIdx] <= 1'b1;
      end
      if (cmd.lockRel) lockState[lockIdx] <= 1'b0;
    end
  end

  // R3
  take_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.lockRd |=> lockState[$past(lockIdx)]);

  // R5
  release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.lockRel |=> !lockState[$past(lockIdx)]);

  // R4
  taken_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.lockRd && lockState[lockIdx]) |=> (busRdata == 32'd1));

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.lockRd || cmd.statusRd) |=> (busRdata == '0));

  // R1
  reserved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busRdata[27:1] == '0);

  // R10
  single_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lockState ^ $past(lockState)) <= 1);

endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
  import hwlock_pkg::*;
#(
  parameter int LOCK_COUNT = 32,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata
);

  localparam int IDX_W = $clog2(LOCK_COUNT);

  lockCmd_t         cmd;
  logic [IDX_W-1:0] lockIdx;

  hwlock_ctrl #(.LOCK_COUNT(LOCK_COUNT), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .busAddr  (busAddr),
    .busRd    (busRd),
    .busWr    (busWr),
    .busWdata (busWdata),
    .cmd      (cmd),
    .lockIdx  (lockIdx)
  );

  hwlock_dp #(.LOCK_COUNT(LOCK_COUNT)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .lockIdx  (lockIdx),
    .busRdata (busRdata)
  );

endmodule

// File: tb/hwlock_bank_tb.sv
module hwlock_bank_tb;

  localparam int N  = 64;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busRd = 1'b0;
  logic          busWr = 1'b0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hwlock_bank #(.LOCK_COUNT(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle; returns busRdata in the following cycle.
  task automatic access(input bit rd, input bit wr, input logic [AW-1:0] a,
                        input logic [31:0] wd, output logic [31:0] rdv);
    @(negedge clk);
    busAddr = a; busRd = rd; busWr = wr; busWdata = wd;
    @(negedge clk);
    busRd = 1'b0; busWr = 1'b0; busWdata = '0;
    rdv = busRdata;
  endtask

  function automatic logic [AW-1:0] lockAddr(input int i);
    return AW'(32'h100 + 4 * i);
  endfunction

  task automatic testReset();
    logic [31:0] r;
    check("R7 rdata after reset", busRdata, 32'h0);
    access(1, 0, lockAddr(0), 0, r);  check("R7 lock0 free", r, 32'h0);
    access(1, 0, lockAddr(N-1), 0, r); check("R7 last lock free", r, 32'h0);
    access(0, 0, lockAddr(N-1), 0, r); // release via write below
    access(0, 1, lockAddr(N-1), 0, r);
  endtask

  task automatic testStatus();
    logic [31:0] r;
    access(1, 0, 12'h000, 0, r); check("R1 status code 2", r, 32'h2000_0000);
    access(0, 1, 12'h000, 32'hFFFF_FFFF, r);
    access(1, 0, 12'h000, 0, r); check("R9 status write ignored", r, 32'h2000_0000);
  endtask

  task automatic testTakeRelease();
    logic [31:0] r;
    access(1, 0, lockAddr(5), 0, r); check("R3 free lock reads 0", r, 32'h0);
    access(1, 0, lockAddr(5), 0, r); check("R10 second reader sees 1", r, 32'h1);
    access(1, 0, lockAddr(5), 0, r); check("R4 taken stays taken", r, 32'h1);
    access(0, 1, lockAddr(5), 32'h1, r);
    access(1, 0, lockAddr(5), 0, r); check("R6 nonzero write no release", r, 32'h1);
    access(0, 1, lockAddr(5), 32'h8000_0000, r);
    access(1, 0, lockAddr(5), 0, r); check("R6 top-bit write no release", r, 32'h1);
    access(0, 1, lockAddr(5), 0, r);
    access(1, 0, lockAddr(5), 0, r); check("R5 zero write releases", r, 32'h0);
    access(0, 1, lockAddr(5), 0, r);
    access(0, 1, lockAddr(5), 0, r);
    access(1, 0, lockAddr(5), 0, r); check("R5 double release stays free", r, 32'h0);
  endtask

  task automatic testAddressing();
    logic [31:0] r;
    access(1, 0, 12'h1FC, 0, r); check("R2 top lock at 0x1FC free", r, 32'h0);
    access(1, 0, lockAddr(N-2), 0, r); check("R2 neighbour independent", r, 32'h0);
    access(1, 0, 12'h1FC, 0, r); check("R2 top lock now taken", r, 32'h1);
  endtask

  task automatic testUnmapped();
    logic [31:0] r;
    access(1, 0, 12'h004, 0, r); check("R8 gap reads 0", r, 32'h0);
    access(1, 0, 12'h200, 0, r); check("R8 index N reads 0", r, 32'h0);
    access(1, 0, 12'h200, 0, r); check("R8 index N never taken", r, 32'h0);
    access(1, 0, 12'h101, 0, r); check("R8 misaligned reads 0", r, 32'h0);
    access(0, 1, 12'h101, 0, r);
    access(0, 1, 12'h200, 0, r);
    access(0, 1, 12'h0FC, 0, r);
    access(1, 0, lockAddr(0), 0, r); check("R8 lock0 untouched by stray writes", r, 32'h1);
  endtask

  task automatic testOverlap();
    logic [31:0] r;
    access(1, 1, lockAddr(9), 0, r); check("R11 rd+wr returns read", r, 32'h0);
    access(1, 0, lockAddr(9), 0, r); check("R11 write part ignored", r, 32'h1);
    access(1, 1, lockAddr(9), 0, r); check("R11 rd+wr on taken", r, 32'h1);
    access(1, 0, lockAddr(9), 0, r); check("R11 not released", r, 32'h1);
  endtask

  task automatic testIdle();
    logic [31:0] r;
    access(1, 0, lockAddr(9), 0, r);
    access(0, 0, lockAddr(9), 0, r); check("R12 idle cycle reads 0", r, 32'h0);
    access(0, 1, 12'h000, 32'h1, r); check("R12 write cycle reads 0", r, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testStatus();
    testTakeRelease();
    testAddressing();
    testUnmapped();
    testOverlap();
    testIdle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule